// File: doc/BRIEF.md
# Power Sleep/Wakeup Step Sequencer

This block walks a fixed chain of power-management steps whenever the CPU platform goes to sleep or comes back. There are six steps. Each is identified by a fixed index: 0 state save/restore, 1 clock gating, 2 PLL, 3 isolation, 4 reset and 5 power switch. A sleep run visits the indices in ascending order. A wakeup run visits them in descending order.

Every step has a 32-bit control word, and the sleep and wakeup directions each have their own set. The control word can skip the step. Otherwise it picks how the step ends: on the responder's done signal, on done followed by a delay, after a fixed count, or on done with a timeout.

For the step in progress, the block raises a one-hot request. It watches the matching done input. It drives busy while a run is in progress, and it pulses complete once the run is over. The power, clock and reset hardware that answers the requests sits outside the block.

Top module: `pwr_step_seq`

## Requirements
- R1: Each control word is laid out as follows:
  - bits 15:0 hold the step count;
  - bits 29:28 hold the finish mode;
  - bit 31 set disables the step.
  - The other bits are ignored.
  - The full 16-bit count is honoured (for example, a count of 257).
- R2: A sleep run uses `sleep_cfg_i` (word k is at bits 32k+31:32k) and serves the enabled steps in index order 0,1,2,3,4,5.
- R3: A wakeup run uses `wake_cfg_i` and serves the enabled steps in index order 5,4,3,2,1,0.
- R4: Mode 0: the step ends in the cycle its done input is high. If done is first high in the step's cycle d (counted from 0), the request is high for d+1 cycles.
- R5: Mode 1: the step waits for done, then stays for a further count cycles. Its request is high for d+1+count cycles.
- R6: Mode 2: done is ignored. The request is high for max(1,count) cycles.
- R7: Mode 3: the step ends on done or on the count, whichever comes first. Its request is high for min(d+1, max(1,count)) cycles.
- R8: A disabled step never raises its request and takes zero cycles. The next enabled step follows directly.
- R9: `step_req_o` (bit k for step k) behaves as follows:
  - it is one-hot or zero;
  - each request stays high from step start to step end;
  - consecutive steps follow back to back;
  - `busy_o` is high exactly when a request is high.
- R10: `complete_o` is a one-cycle pulse in the cycle after the last enabled step ends. If every step is disabled, it comes in the cycle after the start.
- R11: The start inputs have these rules:
  - starts are ignored while busy;
  - if both starts arrive together, sleep wins.
- R12: After reset, `step_req_o`, `busy_o` and `complete_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_start_i | input | 1 | Begin a sleep run (sampled while idle) |
| wake_start_i | input | 1 | Begin a wakeup run (sampled while idle) |
| sleep_cfg_i | input | N*32 | Sleep control words, word k for step k |
| wake_cfg_i | input | N*32 | Wakeup control words, word k for step k |
| step_done_i | input | N | Per-step done from the responders |
| step_req_o | output | N | Per-step request, one-hot |
| busy_o | output | 1 | A run is in progress |
| complete_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
A start sampled at one clock edge raises the first enabled request for the cycle that follows. Each step then holds its request for the number of cycles its mode gives, and `complete_o` appears in the cycle after the sum of all step lengths.

The bench samples on the falling edge. It counts how many cycles each request bit is high, the order in which the bits rise, and the falling-edge index at which complete appears. It compares these with lengths computed from the mode formulas, using responders whose done latency it sets. It also checks the sample after complete, to show that the pulse lasts one cycle and that a start injected mid-run did not restart the sequencer.

// File: rtl/pss_pkg.sv
package pss_pkg;
    localparam int CFG_W    = 32;
    localparam int MODE_LSB = 28;
    localparam int DIS_BIT  = 31;
    localparam int FLD_CNTW = 16;

    typedef enum logic [1:0] {
        MD_DONE  = 2'd0,
        MD_DELAY = 2'd1,
        MD_FIXED = 2'd2,
        MD_TMO   = 2'd3
    } fin_mode_e;

    typedef enum logic {
        DIR_SLEEP = 1'b0,
        DIR_WAKE  = 1'b1
    } run_dir_e;
endpackage

// File: rtl/pss_next_pos.sv
module pss_next_pos #(
    parameter int N  = 6,
    parameter int PW = 3
) (
    input  logic [N-1:0]  dis_sleep_i,
    input  logic [N-1:0]  dis_wake_i,
    input  pss_pkg::run_dir_e dir_i,
    input  logic [PW-1:0] from_i,
    output logic          found_o,
    output logic [PW-1:0] pos_o
);
    import pss_pkg::*;

    logic [N-1:0] dis_ord;

    for (genvar g = 0; g < N; g++) begin : g_ord
        assign dis_ord[g] = (dir_i == DIR_WAKE) ? dis_wake_i[N-1-g] : dis_sleep_i[g];
    end

    always_comb begin
        found_o = 1'b0;
        pos_o   = '0;
        for (int p = N - 1; p >= 0; p--) begin
            if ((PW'(p) >= from_i) && !dis_ord[p]) begin
                found_o = 1'b1;
                pos_o   = PW'(p);
            end
        end
    end
endmodule

// File: rtl/pss_step_end.sv
module pss_step_end #(
    parameter int CNT_W = 16
) (
    input  pss_pkg::fin_mode_e mode_i,
    input  logic [CNT_W-1:0]   limit_i,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic               seen_i,
    input  logic               done_i,
    output logic               finish_o,
    output logic               seen_set_o,
    output logic               count_en_o
);
    import pss_pkg::*;

    logic [CNT_W:0] nxt;
    logic           reach;

    always_comb begin
        nxt   = {1'b0, cnt_i} + {{CNT_W{1'b0}}, 1'b1};
        reach = nxt >= {1'b0, limit_i};
    end

    always_comb begin
        finish_o   = 1'b0;
        seen_set_o = 1'b0;
        count_en_o = 1'b0;
        case (mode_i)
            MD_DONE: finish_o = done_i;
            MD_DELAY: begin
                if (!seen_i) begin
                    finish_o   = done_i && (limit_i == '0);
                    seen_set_o = done_i && (limit_i != '0);
                end else begin
                    finish_o   = reach;
                    count_en_o = 1'b1;
                end
            end
            MD_FIXED: begin
                finish_o   = reach;
                count_en_o = 1'b1;
            end
            MD_TMO: begin
                finish_o   = done_i || reach;
                count_en_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/pwr_step_seq.sv
module pwr_step_seq #(
    parameter int N     = 6,
    parameter int CNT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sleep_start_i,
    input  logic                       wake_start_i,
    input  logic [N*pss_pkg::CFG_W-1:0] sleep_cfg_i,
    input  logic [N*pss_pkg::CFG_W-1:0] wake_cfg_i,
    input  logic [N-1:0]               step_done_i,
    output logic [N-1:0]               step_req_o,
    output logic                       busy_o,
    output logic                       complete_o
);
    import pss_pkg::*;

    localparam int PW = $clog2(N + 1);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic             run;
        run_dir_e         dir;
        logic [PW-1:0]    pos;
        logic [CNT_W-1:0] cnt;
        logic             seen;
        logic             cmpl;
    } st_t;

    st_t st_d, st_q;

    logic [N-1:0]     dis_s, dis_w;
    run_dir_e         start_dir;
    logic             start_found, adv_found;
    logic [PW-1:0]    start_pos, adv_pos, adv_from;
    logic [IW-1:0]    cur_idx;
    logic [CFG_W-1:0] cur_w;
    fin_mode_e        cur_mode;
    logic             fin, seen_set, cnt_en;
    logic             unused_cfg_bits;

    for (genvar g = 0; g < N; g++) begin : g_dis
        assign dis_s[g] = sleep_cfg_i[g*CFG_W + DIS_BIT];
        assign dis_w[g] = wake_cfg_i[g*CFG_W + DIS_BIT];
    end

    assign start_dir = sleep_start_i ? DIR_SLEEP : DIR_WAKE;
    assign adv_from  = st_q.pos + PW'(1);

    pss_next_pos #(.N(N), .PW(PW)) u_start_pos (
        .dis_sleep_i (dis_s),
        .dis_wake_i  (dis_w),
        .dir_i       (start_dir),
        .from_i      ('0),
        .found_o     (start_found),
        .pos_o       (start_pos)
    );

    pss_next_pos #(.N(N), .PW(PW)) u_adv_pos (
        .dis_sleep_i (dis_s),
        .dis_wake_i  (dis_w),
        .dir_i       (st_q.dir),
        .from_i      (adv_from),
        .found_o     (adv_found),
        .pos_o       (adv_pos)
    );

    always_comb begin
        if (st_q.dir == DIR_WAKE) cur_idx = IW'(N - 1) - IW'(st_q.pos);
        else                      cur_idx = IW'(st_q.pos);
        if (st_q.dir == DIR_WAKE) cur_w = wake_cfg_i[cur_idx*CFG_W +: CFG_W];
        else                      cur_w = sleep_cfg_i[cur_idx*CFG_W +: CFG_W];
        cur_mode = fin_mode_e'(cur_w[MODE_LSB +: 2]);
    end

    assign unused_cfg_bits = ^cur_w;

    pss_step_end #(.CNT_W(CNT_W)) u_step_end (
        .mode_i     (cur_mode),
        .limit_i    (cur_w[CNT_W-1:0]),
        .cnt_i      (st_q.cnt),
        .seen_i     (st_q.seen),
        .done_i     (step_done_i[cur_idx]),
        .finish_o   (fin),
        .seen_set_o (seen_set),
        .count_en_o (cnt_en)
    );

    always_comb begin
        st_d      = st_q;
        st_d.cmpl = 1'b0;
        if (!st_q.run) begin
            if (sleep_start_i || wake_start_i) begin
                st_d.dir  = start_dir;
                st_d.cnt  = '0;
                st_d.seen = 1'b0;
                if (start_found) begin
                    st_d.run = 1'b1;
                    st_d.pos = start_pos;
                end else begin
                    st_d.cmpl = 1'b1;
                end
            end
        end else if (fin) begin
            st_d.cnt  = '0;
            st_d.seen = 1'b0;
            if (adv_found) begin
                st_d.pos = adv_pos;
            end else begin
                st_d.run  = 1'b0;
                st_d.cmpl = 1'b1;
            end
        end else if (seen_set) begin
            st_d.seen = 1'b1;
            st_d.cnt  = '0;
        end else if (cnt_en) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        step_req_o = '0;
        if (st_q.run) step_req_o[cur_idx] = 1'b1;
    end

    assign busy_o     = st_q.run;
    assign complete_o = st_q.cmpl;
endmodule

// File: rtl/pss_chk.sv
module pss_chk #(
    parameter int N     = 6,
    parameter int CNT_W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       sleep_start_i,
    input logic                       wake_start_i,
    input logic [N*pss_pkg::CFG_W-1:0] sleep_cfg_i,
    input logic [N*pss_pkg::CFG_W-1:0] wake_cfg_i,
    input logic [N-1:0]               step_done_i,
    input logic [N-1:0]               step_req_o,
    input logic                       busy_o,
    input logic                       complete_o
);
    import pss_pkg::*;

    logic       dir_t;
    logic [1:0] req_mode;
    logic       unused_chk;

    assign unused_chk = (CNT_W > 0) ^ (^sleep_cfg_i) ^ (^wake_cfg_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dir_t <= 1'b0;
        else if (!busy_o && (sleep_start_i || wake_start_i)) dir_t <= !sleep_start_i;
    end

    always_comb begin
        req_mode = 2'd0;
        for (int g = 0; g < N; g++) begin
            if (step_req_o[g])
                req_mode = dir_t ? wake_cfg_i[g*CFG_W + MODE_LSB +: 2]
                                 : sleep_cfg_i[g*CFG_W + MODE_LSB +: 2];
        end
    end

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step_req_o)); // R9
    AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == (step_req_o != '0)); // R9
    AST_CMPL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        complete_o |=> !complete_o); // R10
    AST_CMPL_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> complete_o); // R10
    AST_MODE0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((step_req_o != '0) && (req_mode == 2'd0) && ((step_done_i & step_req_o) == '0))
        |=> (step_req_o == $past(step_req_o))); // R4

    for (genvar g = 0; g < N; g++) begin : g_skip
        AST_SKIP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
            step_req_o[g] |-> !(dir_t ? wake_cfg_i[g*CFG_W + DIS_BIT]
                                      : sleep_cfg_i[g*CFG_W + DIS_BIT])); // R8
    end
endmodule

bind pwr_step_seq pss_chk #(.N(N), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_start_i (sleep_start_i),
    .wake_start_i  (wake_start_i),
    .sleep_cfg_i   (sleep_cfg_i),
    .wake_cfg_i    (wake_cfg_i),
    .step_done_i   (step_done_i),
    .step_req_o    (step_req_o),
    .busy_o        (busy_o),
    .complete_o    (complete_o)
);

// File: tb/pwr_step_seq_tb.sv
`timescale 1ns/1ps
module pwr_step_seq_tb;
    localparam int N = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_start = 1'b0, wake_start = 1'b0;
    logic [N*32-1:0] sleep_cfg, wake_cfg;
    logic [N-1:0]  done, req;
    logic          busy, cmpl;

    logic [31:0] scfg [N];
    logic [31:0] wcfg [N];
    int          lat  [N];
    int          age  [N];
    int          errors = 0, checks = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    always_comb for (int i = 0; i < N; i++) begin
        sleep_cfg[i*32 +: 32] = scfg[i];
        wake_cfg[i*32 +: 32]  = wcfg[i];
        done[i] = req[i] && (age[i] == lat[i]);
    end

    always @(posedge clk)
        for (int i = 0; i < N; i++) age[i] <= req[i] ? age[i] + 1 : 0;

    pwr_step_seq #(.N(N), .CNT_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_start_i(sleep_start), .wake_start_i(wake_start),
        .sleep_cfg_i(sleep_cfg), .wake_cfg_i(wake_cfg), .step_done_i(done),
        .step_req_o(req), .busy_o(busy), .complete_o(cmpl));

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // R1: disable at bit 31, mode at 29:28, count at 15:0
    function automatic logic [31:0] mk(input bit dis, input int mode, input int cnt);
        return {dis, 1'b0, 2'(mode), 12'h0, 16'(cnt)};
    endfunction

    function automatic int exp_len(input logic [31:0] w, input int l);
        int c = int'(w[15:0]);
        int c1 = (c < 1) ? 1 : c;
        if (w[31]) return 0;
        case (w[29:28])
            2'd0: return l + 1;
            2'd1: return l + 1 + c;
            2'd2: return c1;
            default: return (l + 1 < c1) ? l + 1 : c1;
        endcase
    endfunction

    function automatic string mtag(input logic [31:0] w);
        if (w[31]) return "R8";
        case (w[29:28])
            2'd0: return "R4";
            2'd1: return "R5";
            2'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic run_seq(input bit wake, input bit both, input bit poke);
        int len [N];
        int ord [N];
        int eord [N];
        int nord = 0, ne = 0, tot = 0, cmpl_at = -1, bad9 = 0;
        bit wk = wake && !both;
        logic [N-1:0] prev = '0;
        logic [31:0] w;
        for (int i = 0; i < N; i++) begin len[i] = 0; ord[i] = -1; eord[i] = -1; end
        @(negedge clk);
        sleep_start = !wake || both;
        wake_start  = wake || both;
        for (int k = 1; k <= 3000 && cmpl_at < 0; k++) begin
            @(negedge clk);
            sleep_start = 1'b0; wake_start = 1'b0;
            if (poke && k == 3) begin sleep_start = 1'b1; wake_start = 1'b1; end
            for (int i = 0; i < N; i++) begin
                if (req[i]) len[i]++;
                if (req[i] && !prev[i] && nord < N) begin ord[nord] = i; nord++; end
            end
            if ((busy != (req != '0)) || ($countones(req) > 1)) bad9++;
            if (cmpl) cmpl_at = k;
            prev = req;
        end
        for (int p = 0; p < N; p++) begin
            int i = wk ? N - 1 - p : p;
            w = wk ? wcfg[i] : scfg[i];
            tot += exp_len(w, lat[i]);
            if (!w[31]) begin eord[ne] = i; ne++; end
            chk(len[i] == exp_len(w, lat[i]), mtag(w), $sformatf("step %0d request length", i),
                len[i], exp_len(w, lat[i]));
        end
        chk(nord == ne, wk ? "R3" : "R2", "steps served", nord, ne);
        for (int p = 0; p < N; p++)
            chk(ord[p] == eord[p], wk ? "R3" : "R2", $sformatf("order slot %0d", p), ord[p], eord[p]);
        chk(cmpl_at == tot + 1, "R10", "complete sample index", cmpl_at, tot + 1);
        chk(bad9 == 0, "R9", "busy/one-hot violations", bad9, 0);
        @(negedge clk);
        chk(!cmpl && !busy && req == '0, poke ? "R11" : "R10", "idle after complete",
            {cmpl, busy, |req}, 0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin scfg[i] = mk(0, 0, 0); wcfg[i] = mk(0, 0, 0); lat[i] = 0; end
        repeat (3) @(negedge clk);
        chk(req == '0 && !busy && !cmpl, "R12", "outputs in reset", {req, busy, cmpl}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req == '0 && !busy && !cmpl, "R12", "outputs after reset", {req, busy, cmpl}, 0);

        // mode / count / latency / direction sweep: R4 R5 R6 R7 R2 R3
        for (int m = 0; m < 4; m++)
            for (int ci = 0; ci < 3; ci++)
                for (int li = 0; li < 3; li++)
                    for (int d = 0; d < 2; d++) begin
                        int cb = (ci == 0) ? 0 : (ci == 1) ? 1 : 3;
                        int lb = (li == 0) ? 0 : (li == 1) ? 2 : 9;
                        for (int i = 0; i < N; i++) begin
                            scfg[i] = mk(0, m, cb + (i % 3));
                            wcfg[i] = mk(0, m, cb + ((i + 1) % 3));
                            lat[i]  = lb + (i % 2);
                        end
                        run_seq(d[0], 1'b0, 1'b0);
                    end

        // disable masks, every pattern, both directions: R8 R10
        for (int mask = 0; mask < 64; mask++)
            for (int d = 0; d < 2; d++) begin
                for (int i = 0; i < N; i++) begin
                    scfg[i] = mk(mask[i], i % 4, 2);
                    wcfg[i] = mk(mask[N-1-i], (i + 1) % 4, 2);
                    lat[i]  = 1;
                end
                run_seq(d[0], 1'b0, 1'b0);
            end

        // R1: upper count bits honoured
        for (int i = 0; i < N; i++) begin scfg[i] = mk(i != 2, 2, 257); lat[i] = 0; end
        run_seq(1'b0, 1'b0, 1'b0);

        // R11: starts while busy ignored, sleep wins when both arrive
        for (int i = 0; i < N; i++) begin scfg[i] = mk(0, 2, 6); wcfg[i] = mk(0, 2, 4); end
        run_seq(1'b0, 1'b0, 1'b1);
        run_seq(1'b1, 1'b0, 1'b1);
        run_seq(1'b1, 1'b1, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule